// File: doc/BRIEF.md
# GPIO Interrupt Event Capture and Pending Status

This block watches a bank of already-synchronised GPIO pad levels and turns configured transitions or levels into sticky pending bits, one bit per pin. Every pin has its own three-bit trigger control with a positive, a negative and a level enable. With the level enable clear, positive and negative pick rising, falling or both edges. With the level enable set, the same two bits pick an active-high or an active-low level instead. When all three bits are clear the pin is masked.

Pending bits are packed into 32-bit status words. Pin p sits in word p/32 at bit p%32. Software reads one word at a time through a registered read port and acknowledges events by writing ones to the bits it wants cleared. A single interrupt line is high whenever any pending bit in the bank is set. Edges are found by comparing each pad sample with the sample registered one clock earlier. That stored sample is loaded from the pad during reset, so a pad that is already high when reset ends does not look like a rising edge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: With the level enable clear and only the positive enable set, a pin's pending bit is set when the pad is sampled high and the previous clock's sample was low.
- R2: With the level enable clear and only the negative enable set, a pin's pending bit is set when the pad is sampled low and the previous clock's sample was high.
- R3: With the level enable clear and both the positive and negative enables set, either transition sets the pending bit.
- R4: With the level enable set, the pending bit is set on every cycle in which the pad is high (positive enable) or low (negative enable). A cleared bit is set again while the level stays active.
- R5: A pin with neither the positive nor the negative enable set produces no new events, whether or not its level enable is set. Bits that are already pending stay set.
- R6: Pin p is reported in status word p/32 at bit p%32. Bit positions past the last pin, and word indices past the last word, read as zero.
- R7: An acknowledge write clears exactly the bits given as ones in the selected word. Zero bits, and every other word, are left unchanged.
- R8: When an acknowledge and a new event hit the same bit in the same cycle, the bit stays set.
- R9: The interrupt output is high exactly when at least one pending bit is set.
- R10: Synchronous reset clears all pending bits, the read data and the interrupt output. It also loads the previous-level register from the pad, so no edge is seen on the first cycle after reset.
- R11: An event sampled at a clock edge appears on the read data and on the interrupt output immediately after that same edge. The read index is sampled at that edge as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_lvl_i | input | NUM_PINS | Synchronised pad levels |
| cfg_pos_i | input | NUM_PINS | Per-pin positive (rising or high) enable |
| cfg_neg_i | input | NUM_PINS | Per-pin negative (falling or low) enable |
| cfg_lvl_i | input | NUM_PINS | Per-pin level-mode select |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_word_i | input | IDX_W | Status word targeted by the acknowledge |
| ack_bits_i | input | 32 | Write-one-to-clear mask |
| rd_word_i | input | IDX_W | Status word to read |
| rd_data_o | output | 32 | Registered status word |
| irq_o | output | 1 | Combined interrupt, high while any bit is pending |

## Verification
Event capture and the write-one-to-clear acknowledge can land on the same bit in the same cycle. The bench provokes this in two ways. It raises a pad edge on a both-edge pin while acknowledging that pin's bit, and it holds an active level on a level-mode pin while acknowledging it. In both cases the bit must still read as set right after the edge, and the interrupt must stay high. A separate step acknowledges with no event present, which shows that the clear itself takes effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic pos;
    logic neg;
    logic lvl;
  } trig_cfg_t;

  // Decide whether a pin raises an event this cycle.
  function automatic logic trig_event(trig_cfg_t cfg, logic now_lvl, logic prev_lvl);
    logic hit;
    if (cfg.lvl) begin
      hit = (cfg.pos & now_lvl) | (cfg.neg & ~now_lvl);
    end else begin
      hit = (cfg.pos & now_lvl & ~prev_lvl) | (cfg.neg & ~now_lvl & prev_lvl);
    end
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_lvl_i,
  input  logic [NUM_PINS-1:0] cfg_pos_i,
  input  logic [NUM_PINS-1:0] cfg_neg_i,
  input  logic [NUM_PINS-1:0] cfg_lvl_i,
  output logic [NUM_PINS-1:0] evt_o
);

  logic [NUM_PINS-1:0] prev_q;

  // The previous level follows the pad in reset too, so the first
  // cycle out of reset never shows a false edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= pad_lvl_i;
    end else begin
      prev_q <= pad_lvl_i;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_cfg_t cfg;
    always_comb begin
      cfg.pos = cfg_pos_i[p];
      cfg.neg = cfg_neg_i[p];
      cfg.lvl = cfg_lvl_i[p];
      evt_o[p] = trig_event(cfg, pad_lvl_i[p], prev_q[p]);
    end
  end

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] evt_i,
  input  logic              ack_hit_i,
  input  logic [WORD_W-1:0] ack_bits_i,
  output logic [WORD_W-1:0] pend_o,
  output logic [WORD_W-1:0] pend_nxt_o
);

  logic [WORD_W-1:0] pend_q;
  logic [WORD_W-1:0] clr_v;

  always_comb begin
    clr_v      = ack_hit_i ? ack_bits_i : '0;
    // A new event is ORed in after the clear, so it wins on a collision.
    pend_nxt_o = (pend_q & ~clr_v) | evt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_nxt_o;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 40,
  parameter int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
  parameter int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_lvl_i,
  input  logic [NUM_PINS-1:0] cfg_pos_i,
  input  logic [NUM_PINS-1:0] cfg_neg_i,
  input  logic [NUM_PINS-1:0] cfg_lvl_i,
  input  logic                ack_we_i,
  input  logic [IDX_W-1:0]    ack_word_i,
  input  logic [WORD_W-1:0]   ack_bits_i,
  input  logic [IDX_W-1:0]    rd_word_i,
  output logic [WORD_W-1:0]   rd_data_o,
  output logic                irq_o
);

  localparam int FLAT_W = NUM_WORDS * WORD_W;
  localparam int SLOTS  = 1 << IDX_W;

  logic [NUM_PINS-1:0] evt;
  logic [FLAT_W-1:0]   evt_pad;
  logic [FLAT_W-1:0]   pend_all;
  logic [FLAT_W-1:0]   pend_nxt_all;
  logic [WORD_W-1:0]   rd_slot [SLOTS];
  logic [WORD_W-1:0]   rd_q;
  logic                irq_q;

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pad_lvl_i (pad_lvl_i),
    .cfg_pos_i (cfg_pos_i),
    .cfg_neg_i (cfg_neg_i),
    .cfg_lvl_i (cfg_lvl_i),
    .evt_o     (evt)
  );

  always_comb begin
    evt_pad                = '0;
    evt_pad[NUM_PINS-1:0]  = evt;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic ack_hit;
    assign ack_hit = ack_we_i && (ack_word_i == IDX_W'(w));
    gpio_irq_word u_word (
      .clk        (clk),
      .rst        (rst),
      .evt_i      (evt_pad[w*WORD_W +: WORD_W]),
      .ack_hit_i  (ack_hit),
      .ack_bits_i (ack_bits_i),
      .pend_o     (pend_all[w*WORD_W +: WORD_W]),
      .pend_nxt_o (pend_nxt_all[w*WORD_W +: WORD_W])
    );
  end

  // Read slots past the last word return zero.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < NUM_WORDS) begin : g_live
      assign rd_slot[s] = pend_nxt_all[s*WORD_W +: WORD_W];
    end else begin : g_dead
      assign rd_slot[s] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= rd_slot[rd_word_i];
      irq_q <= |pend_nxt_all;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int FLAT_W   = 64
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] pad_lvl_i,
  input logic [NUM_PINS-1:0] cfg_pos_i,
  input logic [NUM_PINS-1:0] cfg_neg_i,
  input logic [NUM_PINS-1:0] cfg_lvl_i,
  input logic                ack_we_i,
  input logic [WORD_W-1:0]   rd_data_o,
  input logic                irq_o,
  input logic [FLAT_W-1:0]   pend_all
);

  logic [NUM_PINS-1:0] pend_d, pad_d, pad_dd, pos_d, neg_d, lvl_d;
  logic                ack_d;
  logic [NUM_PINS-1:0] pend_cur, newly;

  always_ff @(posedge clk) begin
    pend_d <= pend_all[NUM_PINS-1:0];
    pad_d  <= pad_lvl_i;
    pad_dd <= pad_d;
    pos_d  <= cfg_pos_i;
    neg_d  <= cfg_neg_i;
    lvl_d  <= cfg_lvl_i;
    ack_d  <= ack_we_i;
  end

  assign pend_cur = pend_all[NUM_PINS-1:0];
  assign newly    = pend_cur & ~pend_d;

  // R1, R2, R3: a newly set bit of an edge-mode pin needs a pad transition.
  assert_edge_needs_change_R1: assert property (@(posedge clk) disable iff (rst)
    (newly & ~lvl_d & ~(pad_d ^ pad_dd)) == '0);

  // R5: pins with no polarity enable never set a new bit.
  assert_masked_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (newly & ~(pos_d | neg_d)) == '0);

  // R4 and R8: an active level keeps the bit set even under an acknowledge.
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (lvl_d & ((pos_d & pad_d) | (neg_d & ~pad_d)) & ~pend_cur) == '0);

  // R7: a bit only drops after an acknowledge write.
  assert_clear_needs_ack_R7: assert property (@(posedge clk) disable iff (rst)
    ((pend_d & ~pend_cur) != '0) |-> ack_d);

  // R9: interrupt line mirrors the pending bank.
  assert_irq_is_or_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|pend_all));

  // R10: outputs are cleared by reset.
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!irq_o && rd_data_o == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .FLAT_W(FLAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pad_lvl_i (pad_lvl_i),
  .cfg_pos_i (cfg_pos_i),
  .cfg_neg_i (cfg_neg_i),
  .cfg_lvl_i (cfg_lvl_i),
  .ack_we_i  (ack_we_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .pend_all  (pend_all)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

  localparam int NP    = 40;
  localparam int IDX_W = 1;
  localparam int NV    = 20;

  logic            clk = 1'b0;
  logic            rst;
  logic [NP-1:0]   pad, pos, neg, lvl;
  logic            ack_we;
  logic [IDX_W-1:0] ack_word, rd_word;
  logic [31:0]     ack_bits;
  logic [31:0]     rd_data;
  logic            irq;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP)) dut (
    .clk        (clk),
    .rst        (rst),
    .pad_lvl_i  (pad),
    .cfg_pos_i  (pos),
    .cfg_neg_i  (neg),
    .cfg_lvl_i  (lvl),
    .ack_we_i   (ack_we),
    .ack_word_i (ack_word),
    .ack_bits_i (ack_bits),
    .rd_word_i  (rd_word),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  // Row: {pos[3:0], neg[3:0], lvl[3:0], pad[3:0], ack[3:0], exp[3:0], exp_irq}
  localparam logic [24:0] VEC [NV] = '{
    {4'b0101, 4'b0110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0},
    {4'b0101, 4'b0110, 4'b0000, 4'b0001, 4'b0000, 4'b0001, 1'b1},
    {4'b0101, 4'b0110, 4'b0000, 4'b0101, 4'b0000, 4'b0101, 1'b1},
    {4'b0101, 4'b0110, 4'b0000, 4'b0111, 4'b0000, 4'b0101, 1'b1},
    {4'b0101, 4'b0110, 4'b0000, 4'b0110, 4'b0101, 4'b0000, 1'b0},
    {4'b0101, 4'b0110, 4'b0000, 4'b0100, 4'b0000, 4'b0010, 1'b1},
    {4'b0101, 4'b0110, 4'b0000, 4'b0000, 4'b0010, 4'b0100, 1'b1},
    {4'b0101, 4'b0110, 4'b0000, 4'b0000, 4'b0100, 4'b0000, 1'b0},
    {4'b0101, 4'b0110, 4'b0000, 4'b0100, 4'b0100, 4'b0100, 1'b1},
    {4'b0101, 4'b0110, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 1'b0},
    {4'b1000, 4'b0001, 4'b1001, 4'b0000, 4'b0000, 4'b0001, 1'b1},
    {4'b1000, 4'b0001, 4'b1001, 4'b1001, 4'b0001, 4'b1000, 1'b1},
    {4'b1000, 4'b0001, 4'b1001, 4'b1001, 4'b1000, 4'b1000, 1'b1},
    {4'b1000, 4'b0001, 4'b1001, 4'b0001, 4'b1000, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0000, 4'b1110, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0010, 4'b0011, 4'b0000, 4'b0000, 1'b0},
    {4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0},
    {4'b0001, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0001, 1'b1},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b1},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 1'b0}
  };

  localparam string TAG [NV] = '{
    "R10 quiet", "R1 rise", "R3 both rise", "R2 rise ignored",
    "R7 ack two bits", "R2 fall", "R3 fall with R7 ack", "R7 ack",
    "R8 event beats ack", "R7 ack", "R4 low level", "R4 high level",
    "R4 R8 level reasserts", "R4 level gone", "R5 masked",
    "R5 level only", "R1 setup", "R1 rise", "R5 pending held",
    "R7 final ack"
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, sample at the next negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_ack();
    ack_we   = 1'b0;
    ack_bits = '0;
    ack_word = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1;
    pad = '1;
    pos = '1;
    neg = '0;
    lvl = '0;
    rd_word = '0;
    idle_ack();
    repeat (4) @(negedge clk);
    check("R10 reset rd_data", rd_data, 32'h0);
    check("R10 reset irq", {31'b0, irq}, 32'h0);
    rst = 1'b0;
    step();
    check("R10 no edge after reset", rd_data, 32'h0);
    check("R10 irq after reset", {31'b0, irq}, 32'h0);

    // Table walk on pins 0..3, word 0.
    pad = '0;
    pos = '0;
    step();
    for (int i = 0; i < NV; i++) begin
      pos            = '0;
      neg            = '0;
      lvl            = '0;
      pos[3:0]       = VEC[i][24:21];
      neg[3:0]       = VEC[i][20:17];
      lvl[3:0]       = VEC[i][16:13];
      pad            = '0;
      pad[3:0]       = VEC[i][12:9];
      ack_word       = '0;
      ack_bits       = '0;
      ack_bits[3:0]  = VEC[i][8:5];
      ack_we         = |VEC[i][8:5];
      rd_word        = '0;
      step();
      check(TAG[i], rd_data, {28'b0, VEC[i][4:1]});
      check({TAG[i], " R9 irq"}, {31'b0, irq}, {31'b0, VEC[i][0]});
    end
    idle_ack();

    // R6 word mapping: pin 35 is word 1 bit 3.
    pos = '0; neg = '0; lvl = '0; pad = '0;
    step();
    pos[35] = 1'b1;
    pad[35] = 1'b1;
    rd_word = 1'b1;
    step();
    check("R6 R11 pin35 in word1", rd_data, 32'h0000_0008);
    rd_word = 1'b0;
    step();
    check("R6 word0 clear", rd_data, 32'h0);

    // R7 acknowledge targeting the other word or with zero mask.
    ack_we = 1'b1; ack_word = 1'b0; ack_bits = '1; rd_word = 1'b1;
    step();
    check("R7 other word untouched", rd_data, 32'h0000_0008);
    ack_word = 1'b1; ack_bits = '0;
    step();
    check("R7 zero mask no effect", rd_data, 32'h0000_0008);
    ack_bits = '1;
    step();
    check("R7 all ones clears word", rd_data, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);
    idle_ack();

    // R6 unused bits: every pin rises at once.
    pos = '1; pad = '0;
    step();
    pad = '1; rd_word = 1'b1;
    step();
    check("R6 unused bits zero", rd_data, 32'h0000_00FF);
    rd_word = 1'b0;
    step();
    check("R6 full word0", rd_data, 32'hFFFF_FFFF);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    ack_we = 1'b1; ack_bits = '1; ack_word = 1'b0;
    step();
    ack_word = 1'b1;
    step();
    idle_ack();
    step();
    check("R7 bank cleared", {31'b0, irq}, 32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule